// File: doc/BRIEF.md
# Embedded Sync Line Timing Generator

This block produces the horizontal timing of one 4:2:2 digital video line as a byte stream, one byte per clock. Each line opens with a four-byte end-of-active timing code, continues through a blanking fill region, closes that region with a four-byte start-of-active timing code, and then carries the active samples interleaved as Cb, Y, Cr, Y. A free-running sample counter and an active-video flag are brought out beside the data.

The line geometry follows a standard select (525-line or 625-line system) and a square-pixel enable. Square-pixel mode shortens both the active span and the whole line. The field and vertical-blanking flags come from an outer line sequencer that is not part of this block. They are encoded into the timing codes, and the vertical-blanking flag suppresses active samples. All four configuration inputs are captured only at the line boundary, so a line is never altered partway through. Active samples carry a flat colour set by parameters. Upstream logic that has pixel data overwrites the active span using `active_o` and `count_o`.

Top module: `sync_line_gen`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, `data_o` is 0xFF and `active_o` is 0. The first line after reset uses the 525-line normal geometry with field and vertical-blanking bits both 0.
- R2: `count_o` steps by one each clock from 0 up to L-1 and then returns to 0. L is 1716 for the 525-line system in normal mode, 1728 for the 625-line system in normal mode, and 1536 in square-pixel mode for either system. The active span A is 1440 in normal mode and 1280 in square-pixel mode. The blanking span B is L-A.
- R3: At counts 0 to 3 the bytes are 0xFF, 0x00, 0x00, XY with H=1 (end of active). At counts B-4 to B-1 the bytes are 0xFF, 0x00, 0x00, XY with H=0 (start of active).
- R4: The XY byte has bit 7 = 1, bit 6 = F, bit 5 = V and bit 4 = H. Bit 3 is V^H, bit 2 is F^H, bit 1 is F^V and bit 0 is F^V^H.
- R5: At counts 4 to B-5 the byte is 0x80 on even counts and 0x10 on odd counts.
- R6: On a line with V=0, counts B to L-1 carry `CB_LVL`, `Y_LVL`, `CR_LVL`, `Y_LVL` repeating, starting at count B. `active_o` is 1 on exactly those counts.
- R7: On a line with V=1, counts B to L-1 carry 0x80 on even counts and 0x10 on odd counts, and `active_o` stays 0.
- R8: `pal_i`, `sq_pix_i`, `field_i` and `vblank_i` are sampled only at the clock edge where `count_o` goes from L-1 to 0. Any change in these inputs at other times has no effect on the line in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_i | input | 1 | 1 selects the 625-line system, 0 selects the 525-line system |
| sq_pix_i | input | 1 | Square-pixel geometry enable |
| field_i | input | 1 | Field bit for the next line |
| vblank_i | input | 1 | Vertical-blanking bit for the next line |
| data_o | output | 8 | Multiplexed code, fill and sample byte |
| count_o | output | 11 | Sample position within the line |
| active_o | output | 1 | High on active samples of a non-blanked line |

## Verification
Configuration capture and the line wrap share one clock edge. The same edge that returns the counter to 0 also loads the new geometry and flags, and that edge sets both where the line ends and the XY byte at count 3. The bench changes the inputs in the middle of a line, toggles them back and forth, and then sets the geometry of the next line. A cycle-accurate reference model checks that the old line ends at its own length and that the new line's codes, fill and active span follow only the values present at the wrap edge.

// File: rtl/ess_pkg.sv
package ess_pkg;
  typedef struct packed {
    logic pal;
    logic sq;
    logic f;
    logic v;
  } line_cfg_t;

  typedef enum logic [1:0] {
    REG_EAV  = 2'd0,
    REG_FILL = 2'd1,
    REG_SAV  = 2'd2,
    REG_ACT  = 2'd3
  } region_e;

  localparam logic [7:0] TRS_LEAD = 8'hFF;
  localparam logic [7:0] TRS_ZERO = 8'h00;
  localparam logic [7:0] FILL_C   = 8'h80;
  localparam logic [7:0] FILL_Y   = 8'h10;
endpackage

// File: rtl/ess_line_cnt.sv
module ess_line_cnt
  import ess_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  line_cfg_t        cfg_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output line_cfg_t        cfg_o
);
  logic wrap;
  assign wrap = (cnt_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      cfg_o <= '0;
    end else if (wrap) begin
      cnt_o <= '0;
      cfg_o <= cfg_i; // config only moves at line boundary
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ess_span_dec.sv
module ess_span_dec #(
  parameter int CNT_W     = 11,
  parameter int LINE_NTSC = 1716,
  parameter int LINE_PAL  = 1728,
  parameter int LINE_SQ   = 1536,
  parameter int ACT_STD   = 1440,
  parameter int ACT_SQ    = 1280
) (
  input  logic             pal_i,
  input  logic             sq_i,
  output logic [CNT_W-1:0] line_last_o,
  output logic [CNT_W-1:0] blank_len_o
);
  localparam logic [CNT_W-1:0] LAST_NTSC = CNT_W'(LINE_NTSC - 1);
  localparam logic [CNT_W-1:0] LAST_PAL  = CNT_W'(LINE_PAL - 1);
  localparam logic [CNT_W-1:0] LAST_SQ   = CNT_W'(LINE_SQ - 1);
  localparam logic [CNT_W-1:0] BLK_NTSC  = CNT_W'(LINE_NTSC - ACT_STD);
  localparam logic [CNT_W-1:0] BLK_PAL   = CNT_W'(LINE_PAL - ACT_STD);
  localparam logic [CNT_W-1:0] BLK_SQ    = CNT_W'(LINE_SQ - ACT_SQ);

  always_comb begin
    if (sq_i) begin
      line_last_o = LAST_SQ;
      blank_len_o = BLK_SQ;
    end else if (pal_i) begin
      line_last_o = LAST_PAL;
      blank_len_o = BLK_PAL;
    end else begin
      line_last_o = LAST_NTSC;
      blank_len_o = BLK_NTSC;
    end
  end
endmodule

// File: rtl/ess_trs_byte.sv
module ess_trs_byte
  import ess_pkg::*;
(
  input  logic       f_i,
  input  logic       v_i,
  input  logic       h_i,
  input  logic [1:0] idx_i,
  output logic [7:0] byte_o
);
  always_comb begin
    unique case (idx_i)
      2'd0:    byte_o = TRS_LEAD;
      2'd1,
      2'd2:    byte_o = TRS_ZERO;
      default: byte_o = {1'b1, f_i, v_i, h_i,
                         v_i ^ h_i, f_i ^ h_i, f_i ^ v_i, f_i ^ v_i ^ h_i};
    endcase
  end
endmodule

// File: rtl/ess_sample_mux.sv
module ess_sample_mux
  import ess_pkg::*;
#(
  parameter logic [7:0] CB_LVL = 8'h5A,
  parameter logic [7:0] Y_LVL  = 8'h51,
  parameter logic [7:0] CR_LVL = 8'hF0
) (
  input  region_e    region_i,
  input  logic       vblank_i,
  input  logic       parity_i,
  input  logic [1:0] phase_i,
  input  logic [7:0] trs_i,
  output logic [7:0] data_o,
  output logic       active_o
);
  logic [7:0] fill_b;
  assign fill_b = parity_i ? FILL_Y : FILL_C;

  always_comb begin
    active_o = 1'b0;
    unique case (region_i)
      REG_EAV, REG_SAV: data_o = trs_i;
      REG_FILL:         data_o = fill_b;
      default: begin
        if (vblank_i) begin
          data_o = fill_b;
        end else begin
          active_o = 1'b1;
          unique case (phase_i)
            2'd0:    data_o = CB_LVL;
            2'd2:    data_o = CR_LVL;
            default: data_o = Y_LVL;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/sync_line_gen.sv
module sync_line_gen
  import ess_pkg::*;
#(
  parameter int          LINE_NTSC = 1716,
  parameter int          LINE_PAL  = 1728,
  parameter int          LINE_SQ   = 1536,
  parameter int          ACT_STD   = 1440,
  parameter int          ACT_SQ    = 1280,
  parameter logic [7:0]  CB_LVL    = 8'h5A,
  parameter logic [7:0]  Y_LVL     = 8'h51,
  parameter logic [7:0]  CR_LVL    = 8'hF0,
  localparam int         MAX_A     = (LINE_NTSC > LINE_PAL) ? LINE_NTSC : LINE_PAL,
  localparam int         MAX_LINE  = (MAX_A > LINE_SQ) ? MAX_A : LINE_SQ,
  localparam int         CNT_W     = $clog2(MAX_LINE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pal_i,
  input  logic             sq_pix_i,
  input  logic             field_i,
  input  logic             vblank_i,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o
);
  line_cfg_t        cfg_in, cfg_q;
  logic [CNT_W-1:0] cnt_q, line_last, blank_len, sav_start;
  logic [1:0]       phase;
  logic [7:0]       trs_b;
  region_e          region;

  assign cfg_in = '{pal: pal_i, sq: sq_pix_i, f: field_i, v: vblank_i};

  ess_line_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_in),
    .last_i (line_last),
    .cnt_o  (cnt_q),
    .cfg_o  (cfg_q)
  );

  ess_span_dec #(
    .CNT_W(CNT_W), .LINE_NTSC(LINE_NTSC), .LINE_PAL(LINE_PAL),
    .LINE_SQ(LINE_SQ), .ACT_STD(ACT_STD), .ACT_SQ(ACT_SQ)
  ) u_span (
    .pal_i       (cfg_q.pal),
    .sq_i        (cfg_q.sq),
    .line_last_o (line_last),
    .blank_len_o (blank_len)
  );

  assign sav_start = blank_len - CNT_W'(4);

  always_comb begin
    if (cnt_q < CNT_W'(4))          region = REG_EAV;
    else if (cnt_q < sav_start)     region = REG_FILL;
    else if (cnt_q < blank_len)     region = REG_SAV;
    else                            region = REG_ACT;
  end

  // blanking spans are multiples of 4, so low bits give code and sample phase
  assign phase = cnt_q[1:0] - blank_len[1:0];

  ess_trs_byte u_trs (
    .f_i   (cfg_q.f),
    .v_i   (cfg_q.v),
    .h_i   (region == REG_EAV),
    .idx_i (cnt_q[1:0]),
    .byte_o(trs_b)
  );

  ess_sample_mux #(.CB_LVL(CB_LVL), .Y_LVL(Y_LVL), .CR_LVL(CR_LVL)) u_mux (
    .region_i (region),
    .vblank_i (cfg_q.v),
    .parity_i (cnt_q[0]),
    .phase_i  (phase),
    .trs_i    (trs_b),
    .data_o   (data_o),
    .active_o (active_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/sync_line_gen_chk.sv
module sync_line_gen_chk #(
  parameter int CNT_W     = 11,
  parameter int LINE_NTSC = 1716,
  parameter int LINE_PAL  = 1728,
  parameter int LINE_SQ   = 1536
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       data_o,
  input logic [CNT_W-1:0] count_o,
  input logic             active_o
);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) + 1'b1) || (count_o == '0));

  assert_wrap_point_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |=> (count_o != '0) ||
      ($past(count_o) == CNT_W'(LINE_NTSC - 1)) ||
      ($past(count_o) == CNT_W'(LINE_PAL - 1)) ||
      ($past(count_o) == CNT_W'(LINE_SQ - 1)));

  assert_trs_seq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o == 8'hFF) |=> (data_o == 8'h00) ##1 (data_o == 8'h00));

  assert_xy_prot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(data_o, 3) == 8'hFF && $past(data_o, 2) == 8'h00 && $past(data_o, 1) == 8'h00)
    |-> (data_o[7] && data_o[3] == (data_o[5] ^ data_o[4]) &&
         data_o[2] == (data_o[6] ^ data_o[4]) && data_o[1] == (data_o[6] ^ data_o[5]) &&
         data_o[0] == (data_o[6] ^ data_o[5] ^ data_o[4])));

  assert_act_after_sav_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(data_o[7]) && !$past(data_o[4])));
endmodule

bind sync_line_gen sync_line_gen_chk #(
  .CNT_W(CNT_W), .LINE_NTSC(LINE_NTSC), .LINE_PAL(LINE_PAL), .LINE_SQ(LINE_SQ)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_o  (data_o),
  .count_o (count_o),
  .active_o(active_o)
);

// File: tb/sync_line_gen_tb.sv
module sync_line_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] T_CB = 8'h3C, T_Y = 8'h9A, T_CR = 8'hC5;

  logic clk_i = 1'b0;
  logic rst_ni, pal_i, sq_pix_i, field_i, vblank_i;
  logic [7:0]  data_o;
  logic [10:0] count_o;
  logic        active_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sync_line_gen #(.CB_LVL(T_CB), .Y_LVL(T_Y), .CR_LVL(T_CR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pal_i(pal_i), .sq_pix_i(sq_pix_i),
    .field_i(field_i), .vblank_i(vblank_i),
    .data_o(data_o), .count_o(count_o), .active_o(active_o)
  );

  // reference model state
  int h, line_no;
  bit m_pal, m_sq, m_f, m_v;
  bit [3:0] plan_q[$];

  function automatic int len_of(bit pal, bit sq);
    return sq ? 1536 : (pal ? 1728 : 1716);
  endfunction

  function automatic int blank_of(bit pal, bit sq);
    return len_of(pal, sq) - (sq ? 1280 : 1440);
  endfunction

  function automatic logic [7:0] xy_of(bit f, bit v, bit hb);
    logic [7:0] b;
    b[7] = 1; b[6] = f; b[5] = v; b[4] = hb;
    b[3] = v ^ hb; b[2] = f ^ hb; b[1] = f ^ v; b[0] = f ^ v ^ hb;
    return b;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s line %0d count %0d: got %0h expected %0h", req, line_no, h, act, exp);
    end
  endtask

  task automatic compare_cycle();
    int b, k;
    logic [7:0] exp_d;
    bit exp_a;
    string tag;
    b = blank_of(m_pal, m_sq);
    exp_a = 0;
    if (h < 4 || (h >= b - 4 && h < b)) begin
      k = h % 4;
      exp_d = (k == 0) ? 8'hFF : (k == 3) ? xy_of(m_f, m_v, h < 4) : 8'h00;
      tag = (k == 3) ? "R4" : "R3";
    end else if (h < b) begin
      exp_d = (h % 2) ? 8'h10 : 8'h80;
      tag = "R5";
    end else if (m_v) begin
      exp_d = (h % 2) ? 8'h10 : 8'h80;
      tag = "R7";
    end else begin
      k = (h - b) % 4;
      exp_d = (k == 0) ? T_CB : (k == 2) ? T_CR : T_Y;
      exp_a = 1;
      tag = "R6";
    end
    check("R2 count", int'(count_o), h);
    check({tag, " data"}, int'(data_o), int'(exp_d));
    check({tag, " active"}, int'(active_o), int'(exp_a));
    // R8: first active sample follows flags captured at wrap
    if (h == b) check("R8 captured vblank", int'(active_o), int'(!m_v));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit [3:0] nxt;
    // next-line settings {pal, sq, f, v}
    plan_q = '{4'b1010, 4'b1001, 4'b0110, 4'b1100, 4'b0111, 4'b0000};
    rst_ni = 0; pal_i = 0; sq_pix_i = 0; field_i = 0; vblank_i = 0;
    h = 0; line_no = 0; m_pal = 0; m_sq = 0; m_f = 0; m_v = 0;
    // R1: reset state, inputs wiggled during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      pal_i = i[0]; field_i = i[1];
      check("R1 count", int'(count_o), 0);
      check("R1 data", int'(data_o), 8'hFF);
      check("R1 active", int'(active_o), 0);
    end
    pal_i = 0; field_i = 0;
    rst_ni = 1;
    while (line_no < 7) begin
      @(negedge clk_i);
      if (h == len_of(m_pal, m_sq) - 1) begin
        h = 0; line_no++;
        {m_pal, m_sq, m_f, m_v} = {pal_i, sq_pix_i, field_i, vblank_i};
      end else begin
        h++;
      end
      compare_cycle();
      // R8: mid-line disturbance, then settle on next-line values
      if (h == 700) begin
        {pal_i, sq_pix_i, field_i, vblank_i} = ~{m_pal, m_sq, m_f, m_v};
      end else if (h == 900) begin
        {pal_i, sq_pix_i, field_i, vblank_i} = 4'b1111;
      end else if (h == 1100) begin
        nxt = (plan_q.size() > 0) ? plan_q.pop_front() : 4'b0000;
        {pal_i, sq_pix_i, field_i, vblank_i} = nxt;
      end
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      h++;
      compare_cycle();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule